// File: doc/BRIEF.md
# Exception Entry Controller

This block carries out the state changes that a small in-order 32-bit RISC core makes at the moment it takes an exception or an interrupt. The pipeline presents a request with a cause index. It also presents the PC of the faulting instruction, the sequential next PC, the target of a branch whose delay slot is executing, and a flag that marks a delay-slot instruction. On the accepting clock edge the block does five things:

- It picks the address to resume from and stores it in a saved-PC register.
- It copies the live status word into a saved-status register.
- It rewrites the status word for privileged operation with address translation and interrupt sources switched off.
- It loads the fetch unit with the vector of the cause.
- It strobes a translation-buffer flush.

The block owns the live status word. The core can overwrite it through a simple write port, but an exception entry on the same edge takes precedence. A cause index that does not name a defined exception is refused: no state changes and an error pulse is raised instead.

Top module: `exc_entry_ctrl`

## Requirements
- R1: For a valid resume-class cause (indices 5, 8, 12 and 13), the saved PC is `branch_pc` when `in_dslot` is high and `next_pc` otherwise.
- R2: For any other valid cause, the saved PC is `cur_pc - 4` when `in_dslot` is high and `cur_pc` otherwise.
- R3: An entry taken with `in_dslot` high sets status bit 13, the delay-slot-exception bit, and pulses `dslot_clr_o`. An entry taken with `in_dslot` low leaves bit 13 unchanged and keeps `dslot_clr_o` low.
- R4: On an entry, `esr_o` receives the status word as it was before that entry.
- R5: On an entry, the status word changes as follows and all other bits are kept:
  - bit 0 (privileged mode) is set;
  - bit 1 (tick enable), bit 2 (interrupt enable), bit 5 (data translation) and bit 6 (instruction translation) are cleared.
- R6: An accepted request with a valid cause produces one-cycle pulses on `pc_load_o`, `tlb_flush_o` and `entry_done_o` in the cycle after the accepting edge. In that same cycle `new_pc_o` equals the cause index shifted left by 8.
- R7: A request with cause 0, or with a cause of 15 or more, pulses `cause_err_o`. It raises none of `pc_load_o`, `tlb_flush_o` or `entry_done_o`, and it leaves `epc_o`, `esr_o` and the status word unchanged.
- R8: After reset, the status word is 0x00000001 (privileged mode only), `epc_o` and `esr_o` are zero, and all pulse outputs are low.
- R9: With `sr_we` high, `sr_wdata` is loaded into the status word unless a valid entry is accepted on the same edge. In that case the entry result wins.
- R10: Each pulse output is high for exactly one cycle per accepted request, and low in any cycle that follows an edge with no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_req | input | 1 | Exception request, sampled each edge |
| exc_cause | input | 5 | Cause index of the request |
| cur_pc | input | 32 | PC of the faulting instruction |
| next_pc | input | 32 | Sequential next PC |
| branch_pc | input | 32 | Target of the branch owning the delay slot |
| in_dslot | input | 1 | Faulting instruction sits in a delay slot |
| sr_we | input | 1 | Status word write enable |
| sr_wdata | input | 32 | Status word write data |
| sr_o | output | 32 | Live status word |
| esr_o | output | 32 | Saved status word |
| epc_o | output | 32 | Saved exception PC |
| new_pc_o | output | 32 | Vector address for fetch |
| pc_load_o | output | 1 | Fetch redirect pulse |
| tlb_flush_o | output | 1 | Translation-buffer flush pulse |
| entry_done_o | output | 1 | Entry completed pulse |
| cause_err_o | output | 1 | Invalid cause pulse |
| dslot_clr_o | output | 1 | Delay-slot flag clear pulse |

## Verification
The assertions assume that the request, the cause and the three PC inputs are stable across the accepting edge. They compare the registered outputs against `$past` of those inputs, so that stability matters.

The stimulus drives every input on the falling edge and holds a request for exactly one cycle. The PC inputs take distinct, word-aligned values, so that the four saved-PC choices can be told apart. Requests are spaced at least one idle cycle apart, which leaves a cycle in which the pulse outputs must be low.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
    localparam int unsigned XLEN      = 32;
    localparam int unsigned CAUSE_W   = 5;
    localparam int unsigned VEC_SHIFT = 8;

    // status word bit positions
    localparam int unsigned SRB_PRIV  = 0;
    localparam int unsigned SRB_TICKE = 1;
    localparam int unsigned SRB_INTE  = 2;
    localparam int unsigned SRB_DXLAT = 5;
    localparam int unsigned SRB_IXLAT = 6;
    localparam int unsigned SRB_DSEXC = 13;

    localparam logic [XLEN-1:0] SR_RESET = XLEN'(1) << SRB_PRIV;

    typedef struct packed {
        logic [XLEN-1:0] sr;
        logic [XLEN-1:0] esr;
        logic [XLEN-1:0] epc;
        logic [XLEN-1:0] vec;
        logic            pc_load;
        logic            flush;
        logic            done;
        logic            err;
        logic            dsclr;
    } entry_state_t;
endpackage

// File: rtl/exc_cause_decode.sv
module exc_cause_decode #(
    parameter int unsigned CW         = 5,
    parameter int unsigned NUM_CAUSES = 15,
    parameter int unsigned C_TICK     = 5,
    parameter int unsigned C_IRQ      = 8,
    parameter int unsigned C_SYSCALL  = 12,
    parameter int unsigned C_FPE      = 13
) (
    input  logic [CW-1:0] cause,
    output logic          legal,
    output logic          resume
);
    localparam int unsigned NRES = 4;
    localparam int unsigned RES_IDX [NRES] = '{C_TICK, C_IRQ, C_SYSCALL, C_FPE};

    logic [NRES-1:0] hit;

    for (genvar g = 0; g < NRES; g++) begin : g_res
        assign hit[g] = (32'(cause) == RES_IDX[g]);
    end

    assign legal  = (cause != '0) && (32'(cause) < NUM_CAUSES);
    assign resume = |hit;
endmodule

// File: rtl/exc_epc_sel.sv
module exc_epc_sel #(
    parameter int unsigned W      = 32,
    parameter int unsigned INSN_B = 4
) (
    input  logic         in_dslot,
    input  logic         resume,
    input  logic [W-1:0] cur_pc,
    input  logic [W-1:0] next_pc,
    input  logic [W-1:0] branch_pc,
    output logic [W-1:0] epc
);
    always_comb begin
        unique case ({in_dslot, resume})
            2'b11:   epc = branch_pc;
            2'b10:   epc = cur_pc - W'(INSN_B);
            2'b01:   epc = next_pc;
            default: epc = cur_pc;
        endcase
    end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_entry_pkg::*;
#(
    parameter int unsigned NUM_CAUSES = 15,
    parameter int unsigned C_TICK     = 5,
    parameter int unsigned C_IRQ      = 8,
    parameter int unsigned C_SYSCALL  = 12,
    parameter int unsigned C_FPE      = 13
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               exc_req,
    input  logic [CAUSE_W-1:0] exc_cause,
    input  logic [XLEN-1:0]    cur_pc,
    input  logic [XLEN-1:0]    next_pc,
    input  logic [XLEN-1:0]    branch_pc,
    input  logic               in_dslot,
    input  logic               sr_we,
    input  logic [XLEN-1:0]    sr_wdata,
    output logic [XLEN-1:0]    sr_o,
    output logic [XLEN-1:0]    esr_o,
    output logic [XLEN-1:0]    epc_o,
    output logic [XLEN-1:0]    new_pc_o,
    output logic               pc_load_o,
    output logic               tlb_flush_o,
    output logic               entry_done_o,
    output logic               cause_err_o,
    output logic               dslot_clr_o
);
    localparam int unsigned PAD_W = XLEN - CAUSE_W - VEC_SHIFT;

    entry_state_t    st_d, st_q;
    logic            legal_w, resume_w;
    logic [XLEN-1:0] epc_w, sr_entry_w;

    exc_cause_decode #(
        .CW(CAUSE_W), .NUM_CAUSES(NUM_CAUSES), .C_TICK(C_TICK),
        .C_IRQ(C_IRQ), .C_SYSCALL(C_SYSCALL), .C_FPE(C_FPE)
    ) u_dec (
        .cause(exc_cause), .legal(legal_w), .resume(resume_w)
    );

    exc_epc_sel #(.W(XLEN), .INSN_B(4)) u_epc (
        .in_dslot(in_dslot), .resume(resume_w), .cur_pc(cur_pc),
        .next_pc(next_pc), .branch_pc(branch_pc), .epc(epc_w)
    );

    // status word after entry, built from the pre-entry value
    always_comb begin
        sr_entry_w            = st_q.sr;
        sr_entry_w[SRB_PRIV]  = 1'b1;
        sr_entry_w[SRB_TICKE] = 1'b0;
        sr_entry_w[SRB_INTE]  = 1'b0;
        sr_entry_w[SRB_DXLAT] = 1'b0;
        sr_entry_w[SRB_IXLAT] = 1'b0;
        if (in_dslot) sr_entry_w[SRB_DSEXC] = 1'b1;
    end

    always_comb begin
        st_d         = st_q;
        st_d.pc_load = 1'b0;
        st_d.flush   = 1'b0;
        st_d.done    = 1'b0;
        st_d.err     = 1'b0;
        st_d.dsclr   = 1'b0;
        if (sr_we) st_d.sr = sr_wdata;
        if (exc_req) begin
            if (legal_w) begin
                st_d.esr     = st_q.sr;
                st_d.epc     = epc_w;
                st_d.sr      = sr_entry_w;
                st_d.vec     = {{PAD_W{1'b0}}, exc_cause, {VEC_SHIFT{1'b0}}};
                st_d.pc_load = 1'b1;
                st_d.flush   = 1'b1;
                st_d.done    = 1'b1;
                st_d.dsclr   = in_dslot;
            end else begin
                st_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= '0;
            st_q.sr <= SR_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign sr_o         = st_q.sr;
    assign esr_o        = st_q.esr;
    assign epc_o        = st_q.epc;
    assign new_pc_o     = st_q.vec;
    assign pc_load_o    = st_q.pc_load;
    assign tlb_flush_o  = st_q.flush;
    assign entry_done_o = st_q.done;
    assign cause_err_o  = st_q.err;
    assign dslot_clr_o  = st_q.dsclr;

    p_epc_resume_r1: assert property (@(posedge clk) disable iff (!rst_n)
        entry_done_o && $past(resume_w) |->
            epc_o == ($past(in_dslot) ? $past(branch_pc) : $past(next_pc)));

    p_epc_refetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        entry_done_o && !$past(resume_w) |->
            epc_o == ($past(in_dslot) ? $past(cur_pc) - 32'd4 : $past(cur_pc)));

    p_dsexc_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dslot_clr_o |-> sr_o[SRB_DSEXC]);

    p_esr_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        entry_done_o |-> esr_o == $past(sr_o));

    p_priv_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        entry_done_o |-> sr_o[SRB_PRIV] && !sr_o[SRB_TICKE] && !sr_o[SRB_INTE]
                         && !sr_o[SRB_DXLAT] && !sr_o[SRB_IXLAT]);

    p_vector_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load_o |-> new_pc_o == (XLEN'($past(exc_cause)) << VEC_SHIFT));

    p_err_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cause_err_o |-> !pc_load_o && !tlb_flush_o && !entry_done_o
                        && $stable(epc_o) && $stable(esr_o));

    p_pulse_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(exc_req) |-> !tlb_flush_o && !cause_err_o && !dslot_clr_o);
endmodule

// File: tb/exc_entry_ctrl_tb_top.sv
`timescale 1ns/1ps
module exc_entry_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exc_req = 1'b0;
    logic [4:0]  exc_cause = '0;
    logic [31:0] cur_pc = '0, next_pc = '0, branch_pc = '0, sr_wdata = '0;
    logic        in_dslot = 1'b0, sr_we = 1'b0;
    logic [31:0] sr_o, esr_o, epc_o, new_pc_o;
    logic        pc_load_o, tlb_flush_o, entry_done_o, cause_err_o, dslot_clr_o;

    always #2 clk = ~clk;

    exc_entry_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_cause(exc_cause),
        .cur_pc(cur_pc), .next_pc(next_pc), .branch_pc(branch_pc),
        .in_dslot(in_dslot), .sr_we(sr_we), .sr_wdata(sr_wdata),
        .sr_o(sr_o), .esr_o(esr_o), .epc_o(epc_o), .new_pc_o(new_pc_o),
        .pc_load_o(pc_load_o), .tlb_flush_o(tlb_flush_o),
        .entry_done_o(entry_done_o), .cause_err_o(cause_err_o),
        .dslot_clr_o(dslot_clr_o)
    );

    typedef struct {
        int          cyc;
        bit          err;
        bit          resume;
        logic [31:0] sr, esr, epc, vec;
        logic        dsclr;
    } exp_t;

    exp_t        sb_q[$];
    exp_t        it;
    int          cyc = 0;
    int          n_chk = 0, n_fail = 0;
    bit          run = 1'b0, finished = 1'b0;
    logic [31:0] sr_m = 32'h1, esr_m = '0, epc_m = '0;

    always @(posedge clk) cyc++;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // driver: one-cycle request, expected result pushed to the scoreboard
    task automatic send(input logic [4:0] c, input logic ds,
                        input logic [31:0] cp, input logic [31:0] np,
                        input logic [31:0] bp, input logic we = 1'b0,
                        input logic [31:0] wd = '0);
        exp_t e;
        bit   legal, res;
        @(negedge clk);
        exc_req = 1'b1; exc_cause = c; in_dslot = ds;
        cur_pc = cp; next_pc = np; branch_pc = bp;
        sr_we = we; sr_wdata = wd;
        legal = (c != 0) && (c < 15);
        res   = (c == 5) || (c == 8) || (c == 12) || (c == 13);
        e.cyc = cyc; e.err = !legal; e.resume = res; e.dsclr = 1'b0; e.vec = '0;
        if (legal) begin
            esr_m = sr_m;
            epc_m = res ? (ds ? bp : np) : (ds ? cp - 32'd4 : cp);
            sr_m[0] = 1'b1; sr_m[1] = 1'b0; sr_m[2] = 1'b0;
            sr_m[5] = 1'b0; sr_m[6] = 1'b0;
            if (ds) sr_m[13] = 1'b1;
            e.vec = {19'd0, c, 8'd0};
            e.dsclr = ds;
        end else if (we) begin
            sr_m = wd;
        end
        e.sr = sr_m; e.esr = esr_m; e.epc = epc_m;
        sb_q.push_back(e);
        @(negedge clk);
        exc_req = 1'b0; sr_we = 1'b0;
    endtask

    task automatic write_sr(input logic [31:0] wd);
        @(negedge clk);
        sr_we = 1'b1; sr_wdata = wd; sr_m = wd;
        @(negedge clk);
        sr_we = 1'b0;
        chk("R9", "sr after write", sr_o, wd);
    endtask

    // monitor: compare due scoreboard items, else expect quiet pulses
    always @(negedge clk) begin
        if (run) begin
            if (sb_q.size() > 0 && sb_q[0].cyc < cyc) begin
                it = sb_q.pop_front();
                if (it.err) begin
                    chk("R7", "cause_err", 32'(cause_err_o), 32'd1);
                    chk("R7", "pc_load|flush|done",
                        32'(pc_load_o | tlb_flush_o | entry_done_o), 32'd0);
                    chk("R7", "epc kept", epc_o, it.epc);
                    chk("R7", "esr kept", esr_o, it.esr);
                    chk("R7", "sr kept", sr_o, it.sr);
                end else begin
                    chk("R6", "pulses", {29'd0, pc_load_o, tlb_flush_o, entry_done_o}, 32'd7);
                    chk("R6", "vector", new_pc_o, it.vec);
                    chk(it.resume ? "R1" : "R2", "epc", epc_o, it.epc);
                    chk("R4", "esr", esr_o, it.esr);
                    chk("R5", "sr", sr_o, it.sr);
                    chk("R3", "dslot_clr", 32'(dslot_clr_o), 32'(it.dsclr));
                    chk("R7", "no cause_err", 32'(cause_err_o), 32'd0);
                end
            end else begin
                chk("R10", "idle pulses",
                    {27'd0, pc_load_o, tlb_flush_o, entry_done_o, cause_err_o, dslot_clr_o}, 32'd0);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8", "reset sr", sr_o, 32'h1);
        chk("R8", "reset epc", epc_o, 32'h0);
        chk("R8", "reset esr", esr_o, 32'h0);
        chk("R8", "reset pulses",
            {27'd0, pc_load_o, tlb_flush_o, entry_done_o, cause_err_o, dslot_clr_o}, 32'd0);
        run = 1'b1;

        write_sr(32'h0000_0066);                                   // R9 enables on
        send(5'd5,  1'b0, 32'h1000, 32'h1004, 32'h8000);          // R1 tick, no slot
        write_sr(32'h0000_2066);
        send(5'd8,  1'b1, 32'h1100, 32'h1104, 32'h9000);          // R1 irq in slot
        send(5'd12, 1'b0, 32'h2200, 32'h2204, 32'hA000);          // R1 syscall
        send(5'd13, 1'b1, 32'h3300, 32'h3304, 32'hB000);          // R1 fpe in slot
        write_sr(32'h0000_0067);
        send(5'd2,  1'b0, 32'h4400, 32'h4404, 32'hC000);          // R2 refetch
        send(5'd9,  1'b1, 32'h5500, 32'h5504, 32'hD000);          // R2 in slot -> pc-4
        send(5'd14, 1'b0, 32'h6600, 32'h6604, 32'hE000);          // R6 highest valid
        send(5'd1,  1'b1, 32'h7700, 32'h7704, 32'hF000);          // R3 lowest valid
        send(5'd0,  1'b0, 32'h1234, 32'h1238, 32'h5678);          // R7 zero cause
        send(5'd15, 1'b1, 32'h1234, 32'h1238, 32'h5678);          // R7 first undefined
        send(5'd31, 1'b0, 32'h1234, 32'h1238, 32'h5678, 1'b1, 32'h66); // R7 + R9 write
        send(5'd3,  1'b0, 32'h8800, 32'h8804, 32'h0, 1'b1, 32'hFFFF_FFFF); // R9 entry wins
        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule